// File: doc/BRIEF.md
# Multicycle CPU Control Sequencer

This block is the control unit of a small 16-bit processor that executes each instruction over several clock cycles. It is a Moore state machine: a 4-bit state register selects a 17-bit control word that drives the datapath's multiplexer selects and write strobes. The control word depends only on the state. The 4-bit opcode from the instruction register is read only when the machine picks its next state.

Each instruction starts with a fetch cycle and a decode cycle. The decode cycle then branches into a path for its instruction class. Memory loads and stores share an address cycle. Register ALU operations and immediate ALU operations each take an execute cycle and a writeback cycle. Branches, jumps and register jumps finish in one cycle. Jump-and-link takes two cycles. A halt opcode parks the machine in a quiet state that only reset can leave. After reset the machine waits in the fetch state with every control bit low until `start` is seen, and from then on it runs without further prompting.

Top module: `mcs_seq_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) forces `state_o` to 0, `running_o` to 0 and `ctrl_o` to 0.
- R2: While `running_o` is 0, the state stays 0 and `ctrl_o` stays 0. A `start` high at an edge sets `running_o` from the next cycle onward. Once running, `start` has no effect.
- R3: While running, state 0 (fetch) always moves to state 1 at the next edge.
- R4: State 1 dispatches on `opcode_i`: 6 and 7 go to 2; 1, 2, 3, 4 and 10 go to 6; 8 and 9 go to 8; 12 goes to 9; 0, 5 and 11 go to 10; 13 goes to 12; 14 goes to 13; 15 goes to 15.
- R5: From state 2, opcode 6 goes through 3 and then 4, and any other opcode goes to 5. States 4 and 5 return to 0.
- R6: State 6 goes to 7 and state 10 goes to 11. States 7 and 11 return to 0.
- R7: States 8, 9 and 12 return to 0 after one cycle. State 13 goes to 14, and 14 returns to 0.
- R8: `state_o` carries the state number as a 4-bit binary value.
- R9: While running, `ctrl_o` per state is, in hex: 0:1184, 1:0008, 2:2008, 3:1200, 4:4400, 5:0A00, 6:2010, 7:C000, 8:2051, 9:0082, 10:2018, 11:4000, 12:0083, 13:000C, 14:14082, 15:00000. The field layout of `ctrl_o` is: [16:15] register destination select, [14] register write, [13] ALU A select, [12] memory read, [11] memory write, [10] writeback from memory, [9] address from ALU register, [8] instruction register write, [7] PC write, [6] conditional PC write, [5:4] ALU mode, [3:2] ALU B select, [1:0] PC source.
- R10: The ALU mode field `ctrl_o[5:4]` is 01 exactly in states 6, 8 and 10, and 00 in every other state.
- R11: Halt (state 15) keeps every write strobe and every other control bit at 0. It holds regardless of `start` or `opcode_i` until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins execution after reset |
| opcode_i | input | 4 | Opcode field of the instruction register |
| state_o | output | 4 | Current sequencer state number |
| ctrl_o | output | 17 | Control word for the datapath |
| running_o | output | 1 | High once execution has started |

## Verification
On every cycle, the assertions check these rules: fetch always leads to decode, every final cycle of a path returns to fetch, halt is permanent and silent, the idle machine holds fetch with zero controls, and the ALU mode is 01 only in the three operation states. The complete dispatch table, the lw and sw split in state 2, and the exact hex control word in each state can be shown only by the bench. It drives directed and random opcode streams, with stray `start` pulses and a mid-instruction reset, and compares the state trace and `ctrl_o` against its own model.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int OP_W   = 4;
  localparam int ST_W   = 4;
  localparam int CTRL_W = 17;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH  = 4'd0,  ST_DECODE = 4'd1,  ST_MEMADR = 4'd2,  ST_LDRD   = 4'd3,
    ST_LDWB   = 4'd4,  ST_STWR   = 4'd5,  ST_REXE   = 4'd6,  ST_RWB    = 4'd7,
    ST_BRN    = 4'd8,  ST_JMP    = 4'd9,  ST_IEXE   = 4'd10, ST_IWB    = 4'd11,
    ST_JREG   = 4'd12, ST_JAL1   = 4'd13, ST_JAL2   = 4'd14, ST_HALT   = 4'd15
  } seq_state_e;

  localparam logic [OP_W-1:0] OP_LOAD = 4'd6;

  typedef struct packed {
    logic [1:0] dst_sel;
    logic       rf_we;
    logic       alu_a_sel;
    logic       mem_re;
    logic       mem_we;
    logic       wb_from_mem;
    logic       addr_from_alu;
    logic       ir_we;
    logic       pc_we;
    logic       pc_we_cond;
    logic [1:0] alu_mode;
    logic [1:0] alu_b_sel;
    logic [1:0] pc_sel;
  } ctrl_word_t;

  // Next state after decode, chosen by instruction class
  function automatic seq_state_e dispatch_of(input logic [OP_W-1:0] op);
    case (op)
      4'd6, 4'd7:                     return ST_MEMADR;
      4'd1, 4'd2, 4'd3, 4'd4, 4'd10:  return ST_REXE;
      4'd8, 4'd9:                     return ST_BRN;
      4'd12:                          return ST_JMP;
      4'd0, 4'd5, 4'd11:              return ST_IEXE;
      4'd13:                          return ST_JREG;
      4'd14:                          return ST_JAL1;
      default:                        return ST_HALT;
    endcase
  endfunction

  // Control word emitted in each state
  function automatic ctrl_word_t ctrl_of(input seq_state_e s);
    ctrl_word_t c;
    c = '0;
    case (s)
      ST_FETCH: begin
        c.mem_re = 1'b1; c.ir_we = 1'b1; c.pc_we = 1'b1; c.alu_b_sel = 2'b01;
      end
      ST_DECODE: c.alu_b_sel = 2'b10;
      ST_MEMADR: begin c.alu_a_sel = 1'b1; c.alu_b_sel = 2'b10; end
      ST_LDRD:   begin c.mem_re = 1'b1; c.addr_from_alu = 1'b1; end
      ST_LDWB:   begin c.rf_we = 1'b1; c.wb_from_mem = 1'b1; end
      ST_STWR:   begin c.mem_we = 1'b1; c.addr_from_alu = 1'b1; end
      ST_REXE:   begin c.alu_a_sel = 1'b1; c.alu_mode = 2'b01; end
      ST_RWB:    begin c.dst_sel = 2'b01; c.rf_we = 1'b1; end
      ST_BRN: begin
        c.alu_a_sel = 1'b1; c.alu_mode = 2'b01; c.pc_we_cond = 1'b1; c.pc_sel = 2'b01;
      end
      ST_JMP:    begin c.pc_we = 1'b1; c.pc_sel = 2'b10; end
      ST_IEXE: begin
        c.alu_a_sel = 1'b1; c.alu_mode = 2'b01; c.alu_b_sel = 2'b10;
      end
      ST_IWB:    c.rf_we = 1'b1;
      ST_JREG:   begin c.pc_we = 1'b1; c.pc_sel = 2'b11; end
      ST_JAL1:   c.alu_b_sel = 2'b11;
      ST_JAL2: begin
        c.dst_sel = 2'b10; c.rf_we = 1'b1; c.pc_we = 1'b1; c.pc_sel = 2'b10;
      end
      default:   c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/mcs_dispatch.sv
module mcs_dispatch
  import mcs_pkg::*;
(
  input  seq_state_e      cur_st,
  input  logic            run,
  input  logic [OP_W-1:0] opcode,
  output seq_state_e      nxt_st,
  output logic            dispatch_fire
);
  assign dispatch_fire = run && (cur_st == ST_DECODE);

  always_comb begin
    nxt_st = ST_FETCH;
    if (run) begin
      case (cur_st)
        ST_FETCH:  nxt_st = ST_DECODE;
        ST_DECODE: nxt_st = dispatch_of(opcode);
        ST_MEMADR: nxt_st = (opcode == OP_LOAD) ? ST_LDRD : ST_STWR;
        ST_LDRD:   nxt_st = ST_LDWB;
        ST_REXE:   nxt_st = ST_RWB;
        ST_IEXE:   nxt_st = ST_IWB;
        ST_JAL1:   nxt_st = ST_JAL2;
        ST_HALT:   nxt_st = ST_HALT;
        default:   nxt_st = ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/mcs_ctrl_rom.sv
module mcs_ctrl_rom
  import mcs_pkg::*;
(
  input  seq_state_e cur_st,
  input  logic       run,
  output ctrl_word_t ctrl
);
  always_comb begin
    if (run) ctrl = ctrl_of(cur_st);
    else     ctrl = '0;
  end
endmodule

// File: rtl/mcs_state_reg.sv
module mcs_state_reg
  import mcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  seq_state_e nxt_st,
  output seq_state_e cur_st,
  output logic       run
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_st <= ST_FETCH;
      run    <= 1'b0;
    end else begin
      cur_st <= nxt_st;
      run    <= run | start;
    end
  end
endmodule

// File: rtl/mcs_seq_ctrl.sv
module mcs_seq_ctrl
  import mcs_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [OP_W-1:0]     opcode_i,
  output logic [ST_W-1:0]     state_o,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic                running_o
);
  seq_state_e cur_st;
  seq_state_e nxt_st;
  logic       run;
  logic       dispatch_fire;
  logic       halted;
  ctrl_word_t ctrl;

  mcs_state_reg u_reg (
    .clk(clk), .rst(rst), .start(start),
    .nxt_st(nxt_st), .cur_st(cur_st), .run(run)
  );

  mcs_dispatch u_disp (
    .cur_st(cur_st), .run(run), .opcode(opcode_i),
    .nxt_st(nxt_st), .dispatch_fire(dispatch_fire)
  );

  mcs_ctrl_rom u_rom (
    .cur_st(cur_st), .run(run), .ctrl(ctrl)
  );

  assign halted    = (cur_st == ST_HALT);
  assign state_o   = cur_st;
  assign ctrl_o    = ctrl;
  assign running_o = run;
endmodule

// File: rtl/mcs_seq_checker.sv
module mcs_seq_checker (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [3:0]  opcode_i,
  input logic [3:0]  state_o,
  input logic [16:0] ctrl_o,
  input logic        running_o,
  input logic        dispatch_fire,
  input logic        halted
);
  logic [4:0] wr_strobes;
  assign wr_strobes = {ctrl_o[14], ctrl_o[11], ctrl_o[8], ctrl_o[7], ctrl_o[6]};

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (state_o == 4'd0 && !running_o && ctrl_o == '0)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !running_o |-> (state_o == 4'd0 && ctrl_o == '0)); // R2

  AST_RUN_STICKS: assert property (@(posedge clk) disable iff (rst)
    running_o |=> running_o); // R2

  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
    (running_o && state_o == 4'd0) |=> state_o == 4'd1); // R3

  AST_DECODE_LEAVES: assert property (@(posedge clk) disable iff (rst)
    dispatch_fire |=> (state_o != 4'd0 && state_o != 4'd1)); // R4

  AST_HALT_DECODE: assert property (@(posedge clk) disable iff (rst)
    (dispatch_fire && opcode_i == 4'd15) |=> halted); // R4

  AST_LOAD_TAIL: assert property (@(posedge clk) disable iff (rst)
    state_o == 4'd3 |=> state_o == 4'd4); // R5

  AST_PATH_END: assert property (@(posedge clk) disable iff (rst)
    (state_o inside {4'd4, 4'd5, 4'd7, 4'd11}) |=> state_o == 4'd0); // R6

  AST_SHORT_END: assert property (@(posedge clk) disable iff (rst)
    (state_o inside {4'd8, 4'd9, 4'd12, 4'd14}) |=> state_o == 4'd0); // R7

  AST_ALU_MODE: assert property (@(posedge clk) disable iff (rst)
    (ctrl_o[5:4] != 2'b00) |-> (ctrl_o[5:4] == 2'b01 && state_o inside {4'd6, 4'd8, 4'd10})); // R10

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R11

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
    halted |-> (wr_strobes == '0 && ctrl_o == '0)); // R11

  AST_ONE_STROBE_PC: assert property (@(posedge clk) disable iff (rst)
    $countones({ctrl_o[7], ctrl_o[6]}) <= 1); // R9

  logic unused_in;
  assign unused_in = start;
endmodule

bind mcs_seq_ctrl mcs_seq_checker chk_i (
  .clk(clk), .rst(rst), .start(start), .opcode_i(opcode_i),
  .state_o(state_o), .ctrl_o(ctrl_o), .running_o(running_o),
  .dispatch_fire(dispatch_fire), .halted(halted)
);

// File: tb/mcs_seq_ctrl_tb.sv
module mcs_seq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  opcode_i = 4'd0;
  logic [3:0]  state_o;
  logic [16:0] ctrl_o;
  logic        running_o;

  int checks = 0;
  int fails  = 0;
  int m_state = 0;
  bit m_run = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mcs_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .start(start), .opcode_i(opcode_i),
    .state_o(state_o), .ctrl_o(ctrl_o), .running_o(running_o)
  );

  // Successor per the state graph (R3..R7, R11)
  function automatic int succ(input int s, input int op);
    case (s)
      0: return 1;
      1: begin
        if (op == 6 || op == 7) return 2;
        if (op inside {1, 2, 3, 4, 10}) return 6;
        if (op == 8 || op == 9) return 8;
        if (op == 12) return 9;
        if (op inside {0, 5, 11}) return 10;
        if (op == 13) return 12;
        if (op == 14) return 13;
        return 15;
      end
      2: return (op == 6) ? 3 : 5;
      3: return 4;
      6: return 7;
      10: return 11;
      13: return 14;
      15: return 15;
      default: return 0;
    endcase
  endfunction

  // Expected control word per state (R9)
  function automatic logic [16:0] word_for(input int s);
    logic [16:0] t [16] = '{17'h01184, 17'h00008, 17'h02008, 17'h01200,
                            17'h04400, 17'h00A00, 17'h02010, 17'h0C000,
                            17'h02051, 17'h00082, 17'h02018, 17'h04000,
                            17'h00083, 17'h0000C, 17'h14082, 17'h00000};
    return t[s];
  endfunction

  function automatic string tag_of(input int s, input bit r);
    if (!r) return "R2";
    case (s)
      0: return "R3";
      1: return "R4";
      2, 3, 4, 5: return "R5";
      6, 7, 10, 11: return "R6";
      15: return "R11";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h state=%0d", tag, act, exp, m_state);
    end
  endtask

  // Advance one clock using the inputs already applied, then compare at negedge
  task automatic cycle();
    int ns;
    bit nr;
    if (rst) begin ns = 0; nr = 1'b0; end
    else if (!m_run) begin ns = 0; nr = start; end
    else begin ns = succ(m_state, opcode_i); nr = 1'b1; end
    @(negedge clk);
    m_state = ns;
    m_run = nr;
    if (rst) begin
      chk("R1 state", 32'(state_o), 0);
      chk("R1 running", 32'(running_o), 0);
      chk("R1 ctrl", 32'(ctrl_o), 0);
    end else begin
      chk({tag_of(m_state, m_run), " state (R8)"}, 32'(state_o), 32'(m_state));
      chk("R2 running", 32'(running_o), 32'(m_run));
      chk(m_run ? "R9 ctrl" : "R2 ctrl", 32'(ctrl_o),
          m_run ? 32'(word_for(m_state)) : 0);
      chk("R10 alu mode", 32'(ctrl_o[5:4]),
          (m_run && m_state inside {6, 8, 10}) ? 1 : 0);
    end
  endtask

  // Run one instruction from fetch back to fetch (or into halt)
  task automatic run_instr(input int op, input bit noisy_start);
    opcode_i = 4'(op);
    do begin
      if (noisy_start) start = 1'($urandom % 2);
      cycle();
    end while (m_state != 0 && m_state != 15);
    start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1: reset
    rst = 1'b1;
    cycle();
    cycle();
    rst = 1'b0;
    // R2: idle with noise on the opcode, no start
    for (int i = 0; i < 6; i++) begin
      opcode_i = 4'($urandom % 16);
      cycle();
    end
    start = 1'b1;
    cycle();
    start = 1'b0;
    // Directed: every non-halt opcode once
    for (int op = 0; op < 15; op++) run_instr(op, 1'b0);
    // Random stream with stray start pulses (R2 ignored while running)
    for (int i = 0; i < 400; i++) run_instr(int'($urandom % 15), 1'b1);
    // Reset in the middle of a load (R1), then restart
    opcode_i = 4'd6;
    cycle(); cycle(); cycle();
    rst = 1'b1;
    cycle();
    rst = 1'b0;
    cycle();
    start = 1'b1;
    cycle();
    start = 1'b0;
    run_instr(7, 1'b0);
    run_instr(14, 1'b0);
    // R11: halt, then noise on start and opcode
    run_instr(15, 1'b0);
    for (int i = 0; i < 8; i++) begin
      start = 1'($urandom % 2);
      opcode_i = 4'($urandom % 16);
      cycle();
    end
    chk("R11 halted state", 32'(state_o), 15);
    start = 1'b0;
    // R1: reset releases halt
    rst = 1'b1;
    cycle();
    rst = 1'b0;
    start = 1'b1;
    cycle();
    start = 1'b0;
    run_instr(3, 1'b0);
    chk("R1 recovered state", 32'(state_o), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule